// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block turns a programmed mode word into the column address sequence of one SDRAM-style read or write burst. A controller first loads the mode word, which holds a burst length code, an ordering bit and a read latency code. It then pulses a start strobe with an 8-bit starting column and a read/write flag. The block presents one column per clock for the programmed number of beats and pulses a done flag when the burst ends. For reads, it also raises a data-valid flag that trails the address beats by the programmed latency.

Beats are ordered either by counting upward modulo 256 or by XOR-ing the beat index into the low bits of the start column. A full-page length runs without end until a terminate strobe arrives. The column output is a plain valid-qualified stream with no ready input, because an SDRAM burst cannot be stalled. The consumer must accept one beat on every cycle in which the valid flag is high. If the mode word holds a reserved code, the block raises an error flag and refuses to start until a legal mode is loaded.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, col_valid, burst_done and rd_data_valid are low and mode_err is low. The loaded mode is length 1, sequential, latency 2, so a start yields exactly one beat.
- R2: A start sampled while idle and error-free puts beat 0 (the start column) on col_addr in the cycle after the strobe. col_valid then stays high for exactly the burst length of consecutive cycles. The length code sits in mode_word[2:0]: 000=1, 001=2, 010=4, 011=8.
- R3: With mode_word[3]=0 (sequential), beat k carries (start column + k) modulo 256.
- R4: With mode_word[3]=1 (interleaved), beat k carries the start column XOR k. Bits 7..3 stay equal to those of the start column.
- R5: Length code 111 (full page) produces beats that keep counting upward modulo 256 until a terminate is seen. The ordering bit is ignored in this mode, and ordering is always sequential.
- R6: burst_done is a one-cycle pulse in the cycle right after the last beat of a burst.
- R7: A terminate sampled during a burst makes col_valid low in the next cycle, and burst_done pulses in that same cycle. A terminate while idle has no effect.
- R8: A start sampled while a burst is active, including on its last beat, is ignored. The running beats are unchanged and no further beats follow.
- R9: For a read burst, rd_data_valid equals col_valid delayed by the latency in clock cycles. The latency code sits in mode_word[6:4]: 010=2, 011=3. Beats issued before a terminate still produce their data-valid cycles.
- R10: For a write burst, rd_data_valid stays low.
- R11: Loading a reserved length code (100, 101, 110) or a reserved latency code (anything except 010 or 011) sets mode_err in the cycle after the load. While mode_err is high, starts are ignored. Loading a legal mode clears mode_err and starts work again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Loads mode_word on this edge |
| mode_word | input | 7 | [6:4] latency code, [3] ordering, [2:0] length code |
| start | input | 1 | Begin a burst at start_col |
| start_col | input | 8 | First column of the burst |
| is_read | input | 1 | 1 = read burst, 0 = write burst |
| terminate | input | 1 | End the active burst |
| col_addr | output | 8 | Column of the current beat |
| col_valid | output | 1 | col_addr holds a beat |
| burst_done | output | 1 | One-cycle pulse after a burst ends |
| rd_data_valid | output | 1 | Read data expected on this cycle |
| mode_err | output | 1 | Loaded mode holds a reserved code |

## Verification
The assertions assume that a controller changes the latency code only when no read data is still in flight. They also assume that mode_load is not pulsed in the same cycle as an accepted start. The directed stimulus loads every mode word while the block is idle and waits a few cycles after each burst's last data-valid cycle before it loads the next mode. Start, terminate and mode strobes are all driven on the falling edge, so each is sampled by exactly one rising edge.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;
  // mode word layout: [6:4] latency code, [3] ordering, [2:0] length code
  localparam int MODE_W = 7;

  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  typedef enum logic [2:0] {
    LAT_2 = 3'b010,
    LAT_3 = 3'b011
  } lat_code_e;

  function automatic logic len_legal(input logic [2:0] c);
    return (c == LEN_1) || (c == LEN_2) || (c == LEN_4) ||
           (c == LEN_8) || (c == LEN_PAGE);
  endfunction

  function automatic logic lat_legal(input logic [2:0] c);
    return (c == LAT_2) || (c == LAT_3);
  endfunction
endpackage

// File: rtl/bcs_mode_reg.sv
`timescale 1ns/1ps
module bcs_mode_reg
  import bcs_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int CLW   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output logic [COL_W-1:0]  last_idx,
  output logic              full_page,
  output logic              interleave,
  output logic [CLW-1:0]    lat,
  output logic              err
);
  logic [2:0] len_q;
  logic       ord_q;
  logic [2:0] lat_q;
  logic       err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= LEN_1;
      ord_q <= 1'b0;
      lat_q <= LAT_2;
      err_q <= 1'b0;
    end else if (load) begin
      len_q <= word[2:0];
      ord_q <= word[3];
      lat_q <= word[6:4];
      err_q <= !(len_legal(word[2:0]) && lat_legal(word[6:4]));
    end
  end

  always_comb begin
    full_page = (len_q == LEN_PAGE);
    unique case (len_q)
      LEN_2:   last_idx = COL_W'(1);
      LEN_4:   last_idx = COL_W'(3);
      LEN_8:   last_idx = COL_W'(7);
      default: last_idx = '0;
    endcase
    // XOR ordering has no meaning over a whole page: fall back to counting
    interleave = ord_q && !full_page;
    lat        = lat_q[0] ? CLW'(3) : CLW'(2);
    err        = err_q;
  end

  // R11: error flag only moves on a load
  assert_err_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(err));
endmodule

// File: rtl/bcs_addr_gen.sv
`timescale 1ns/1ps
module bcs_addr_gen #(
  parameter int COL_W = 8,
  parameter int CLW   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             is_read,
  input  logic             terminate,
  input  logic             mode_ok,
  input  logic [COL_W-1:0] last_idx,
  input  logic             full_page,
  input  logic             interleave,
  input  logic [CLW-1:0]   lat,
  output logic [COL_W-1:0] col_addr,
  output logic             col_valid,
  output logic             done,
  output logic             rd_beat,
  output logic [CLW-1:0]   lat_q
);
  logic             busy_q, done_q, fp_q, ilv_q, rd_q;
  logic [COL_W-1:0] base_q, beat_q, last_q;
  logic             ending;
  logic [COL_W-1:0] seq_next;

  assign ending = busy_q && (terminate || (!fp_q && beat_q == last_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      fp_q   <= 1'b0;
      ilv_q  <= 1'b0;
      rd_q   <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      last_q <= '0;
      lat_q  <= CLW'(2);
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start && mode_ok) begin
          busy_q <= 1'b1;
          base_q <= start_col;
          beat_q <= '0;
          last_q <= last_idx;
          fp_q   <= full_page;
          ilv_q  <= interleave;
          rd_q   <= is_read;
          lat_q  <= lat;
        end
      end else if (ending) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  always_comb begin
    col_addr  = ilv_q ? (base_q ^ beat_q) : (base_q + beat_q);
    col_valid = busy_q;
    done      = done_q;
    rd_beat   = busy_q && rd_q;
    seq_next  = col_addr + 1'b1;
  end

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !ending) |=> (busy_q && $stable(base_q)));
  assert_term_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && terminate) |=> (!col_valid && done));
  assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ilv_q && !ending) |=> (col_addr == $past(seq_next)));
  assert_ilv_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ilv_q && !ending) |=> (col_addr[COL_W-1:3] == $past(col_addr[COL_W-1:3])));
endmodule

// File: rtl/bcs_rd_pipe.sv
`timescale 1ns/1ps
module bcs_rd_pipe #(
  parameter int MAX_CL = 3,
  parameter int CLW    = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           feed,
  input  logic [CLW-1:0] lat,
  output logic           rd_valid
);
  logic [MAX_CL-1:0] stage_q;

  generate
    for (genvar g = 0; g < MAX_CL; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[g] <= 1'b0;
        else if (g == 0) stage_q[g] <= feed;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_comb begin
    rd_valid = 1'b0;
    for (int g = 0; g < MAX_CL; g++)
      if (lat == CLW'(g + 1)) rd_valid = stage_q[g];
  end

  // R9: data-valid only follows a read beat issued two or three cycles earlier
  assert_rd_after_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(feed, 2) || $past(feed, 3)));
endmodule

// File: rtl/burst_col_seq.sv
`timescale 1ns/1ps
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MAX_CL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              is_read,
  input  logic              terminate,
  output logic [COL_W-1:0]  col_addr,
  output logic              col_valid,
  output logic              burst_done,
  output logic              rd_data_valid,
  output logic              mode_err
);
  localparam int CLW = $clog2(MAX_CL + 1);

  logic [COL_W-1:0] last_idx;
  logic             full_page, interleave, rd_beat;
  logic [CLW-1:0]   lat, lat_q;

  bcs_mode_reg #(.COL_W(COL_W), .CLW(CLW)) u_mode (
    .clk(clk), .rst_n(rst_n), .load(mode_load), .word(mode_word),
    .last_idx(last_idx), .full_page(full_page), .interleave(interleave),
    .lat(lat), .err(mode_err)
  );

  bcs_addr_gen #(.COL_W(COL_W), .CLW(CLW)) u_addr (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .is_read(is_read), .terminate(terminate), .mode_ok(!mode_err),
    .last_idx(last_idx), .full_page(full_page), .interleave(interleave),
    .lat(lat), .col_addr(col_addr), .col_valid(col_valid),
    .done(burst_done), .rd_beat(rd_beat), .lat_q(lat_q)
  );

  bcs_rd_pipe #(.MAX_CL(MAX_CL), .CLW(CLW)) u_pipe (
    .clk(clk), .rst_n(rst_n), .feed(rd_beat), .lat(lat_q),
    .rd_valid(rd_data_valid)
  );

  assert_err_blocks_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_err && !col_valid && start) |=> !col_valid);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);
  assert_done_after_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> (!col_valid && $past(col_valid)));
endmodule

// File: tb/test_burst_col_seq.sv
`timescale 1ns/1ps
module test_burst_col_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_load = 1'b0;
  logic [6:0] mode_word = '0;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic       is_read = 1'b0;
  logic       terminate = 1'b0;
  logic [7:0] col_addr;
  logic       col_valid, burst_done, rd_data_valid, mode_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] ca [0:299];
  bit cv [0:299];
  bit cd [0:299];
  bit cr [0:299];

  always #2 clk = ~clk;

  burst_col_seq i_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
    .start(start), .start_col(start_col), .is_read(is_read),
    .terminate(terminate), .col_addr(col_addr), .col_valid(col_valid),
    .burst_done(burst_done), .rd_data_valid(rd_data_valid), .mode_err(mode_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_mode(input logic [6:0] w);
    @(negedge clk); mode_load = 1'b1; mode_word = w;
    @(negedge clk); mode_load = 1'b0;
  endtask

  // index i holds the outputs after the i-th rising edge following the start
  task automatic run(input logic [7:0] col, input logic rd, input int n,
                     input int term_at, input int restart_at);
    @(negedge clk); start = 1'b1; start_col = col; is_read = rd;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 1'b0; terminate = 1'b0;
      ca[i] = col_addr; cv[i] = col_valid; cd[i] = burst_done; cr[i] = rd_data_valid;
      if (i == term_at) terminate = 1'b1;
      if (i == restart_at) begin start = 1'b1; start_col = 8'hAA; end
    end
    @(negedge clk); start = 1'b0; terminate = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_burst(input string req, input logic [7:0] col, input bit ilv,
                             input int nb, input bit rd, input int cl, input int n);
    int beats = 0, dones = 0, rds = 0;
    for (int i = 0; i < n; i++) begin
      bit ev = (i < nb);
      bit er = rd && (i >= cl) && (i < cl + nb);
      if (cv[i] != ev) chk({req, " valid"}, cv[i], ev);
      if (ev) begin
        logic [7:0] ea = ilv ? (col ^ 8'(i)) : 8'(col + 8'(i));
        if (ca[i] != ea) chk({req, " addr"}, ca[i], ea);
      end
      if (cd[i] != (i == nb)) chk("R6 done", cd[i], (i == nb));
      if (cr[i] != er) chk({req, " rd_valid R9/R10"}, cr[i], er);
      beats += cv[i]; dones += cd[i]; rds += cr[i];
    end
    chk({req, " beat count"}, beats, nb);
    chk("R6 done count", dones, 1);
    chk("R9/R10 rd_valid count", rds, rd ? nb : 0);
  endtask

  task automatic t_reset();
    chk("R1 col_valid", col_valid, 0);
    chk("R1 burst_done", burst_done, 0);
    chk("R1 rd_data_valid", rd_data_valid, 0);
    chk("R1 mode_err", mode_err, 0);
    run(8'h37, 1'b1, 6, -1, -1);
    check_burst("R1 default mode", 8'h37, 0, 1, 1, 2, 6);
  endtask

  task automatic t_seq();
    load_mode(7'b010_0_010);
    run(8'hFD, 1'b0, 8, -1, -1);
    check_burst("R2 R3 seq4 wrap write", 8'hFD, 0, 4, 0, 2, 8);
    load_mode(7'b011_0_011);
    run(8'h10, 1'b1, 14, -1, -1);
    check_burst("R2 R3 seq8 read lat3", 8'h10, 0, 8, 1, 3, 14);
    load_mode(7'b010_0_001);
    run(8'hFF, 1'b1, 6, -1, -1);
    check_burst("R2 R3 seq2 read", 8'hFF, 0, 2, 1, 2, 6);
  endtask

  task automatic t_ilv();
    load_mode(7'b010_1_011);
    run(8'h5B, 1'b1, 13, -1, -1);
    check_burst("R4 ilv8 read lat2", 8'h5B, 1, 8, 1, 2, 13);
    load_mode(7'b011_1_001);
    run(8'h03, 1'b0, 6, -1, -1);
    check_burst("R4 ilv2 write", 8'h03, 1, 2, 0, 3, 6);
    load_mode(7'b010_1_010);
    run(8'hC6, 1'b0, 7, -1, -1);
    check_burst("R4 ilv4 write", 8'hC6, 1, 4, 0, 2, 7);
  endtask

  task automatic t_page();
    load_mode(7'b010_1_111);
    run(8'hFE, 1'b0, 264, 259, -1);
    check_burst("R5 R7 full page", 8'hFE, 0, 260, 0, 2, 264);
  endtask

  task automatic t_term();
    load_mode(7'b010_0_011);
    run(8'h80, 1'b1, 10, 2, -1);
    check_burst("R7 R9 terminate read", 8'h80, 0, 3, 1, 2, 10);
    @(negedge clk); terminate = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); terminate = 1'b0;
      chk("R7 idle terminate valid", col_valid, 0);
      chk("R7 idle terminate done", burst_done, 0);
    end
  endtask

  task automatic t_restart();
    load_mode(7'b010_0_010);
    run(8'h20, 1'b0, 9, -1, 1);
    check_burst("R8 start mid burst", 8'h20, 0, 4, 0, 2, 9);
    run(8'h30, 1'b0, 9, -1, 3);
    check_burst("R8 start on last beat", 8'h30, 0, 4, 0, 2, 9);
  endtask

  task automatic t_err();
    logic [6:0] bad [0:2];
    bad[0] = 7'b010_0_100; bad[1] = 7'b001_0_010; bad[2] = 7'b110_0_010;
    for (int b = 0; b < 3; b++) begin
      int seen = 0;
      load_mode(bad[b]);
      chk("R11 mode_err set", mode_err, 1);
      run(8'h40, 1'b1, 6, -1, -1);
      for (int i = 0; i < 6; i++) seen += cv[i] + cr[i] + cd[i];
      chk("R11 start ignored", seen, 0);
    end
    load_mode(7'b010_0_001);
    chk("R11 mode_err cleared", mode_err, 0);
    run(8'h41, 1'b1, 6, -1, -1);
    check_burst("R11 recovered", 8'h41, 0, 2, 1, 2, 6);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seq();
    t_ilv();
    t_page();
    t_term();
    t_restart();
    t_err();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule